// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a compact predicate specification into per-element enable masks for a vector operation. A single kind bit chooses between integer predication, where the mask comes from one of three fixed 64-bit integer registers, and condition-register predication, where each element tests one bit of its own 4-bit condition register. Two independent 3-bit selector fields, both read under the same kind, give a destination mask and a source mask, so twin predication can use the same register, different registers, or different condition tests for its two sides.

A request is offered with a valid/ready handshake. Both masks are computed from the inputs present in the accept cycle and are registered. The output side also uses valid/ready. `req_ready` is high when the output register is empty or is being drained in the same cycle (`!mask_valid || mask_ready`). While `mask_valid` is high and `mask_ready` is low, the masks are held and no new request is taken. With `mask_ready` tied high, each accepted request gives a one-cycle `mask_valid` pulse.

Top module: `pred_mask_gen`

## Requirements
- R1: `kind`=0 decodes both selector fields as integer codes, and `kind`=1 decodes both as condition-register codes. The two kinds are never mixed within one request.
- R2: Integer code 000 enables every element below the vector length.
- R3: Integer code 001 enables only the element whose index equals `r3`. If `r3` is 64 or more, the mask is all zero.
- R4: Integer codes 010 to 111 test bit i of a register. Selector bits [2:1] pick the register: 01 for `r3`, 10 for `r10`, 11 for `r30`. Selector bit 0 = 0 enables the element when the bit is set, and bit 0 = 1 enables it when the bit is clear.
- R5: In condition-register mode, element i reads entry 32+i, which occupies `crf[4k+3:4k]` for entry k. Selector bits [2:1] pick the tested bit: 00 for LT (bit 3), 01 for GT (bit 2), 10 for EQ (bit 1), 11 for SO/unordered (bit 0). Selector bit 0 = 0 enables the element when the bit is set, and bit 0 = 1 enables it when the bit is clear.
- R6: In condition-register mode, any element whose entry index 32+i exceeds 63 is disabled, so mask bits 32 to 63 are zero.
- R7: `src_mask` is decoded from `src_sel` independently of `dst_mask`, which is decoded from `dst_sel`.
- R8: Mask bits at positions equal to or above `vlen` are zero. `vlen`=0 gives an all-zero mask, and values above 64 act as 64.
- R9: A request is accepted when `req_valid && req_ready`, where `req_ready = !mask_valid || mask_ready`. The masks and `mask_valid` appear on the next cycle. `mask_valid` falls after a cycle with `mask_ready` high and no new accept.
- R10: While `mask_valid` is high and `mask_ready` is low, both masks and `mask_valid` stay unchanged.
- R11: A synchronous reset clears `mask_valid` and both masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| kind | input | 1 | 0 = integer predication, 1 = condition-register predication |
| dst_sel | input | 3 | Destination predicate code |
| src_sel | input | 3 | Source predicate code |
| vlen | input | 7 | Vector length (0 to 64) |
| r3 | input | 64 | Integer predicate source / one-hot index |
| r10 | input | 64 | Integer predicate source |
| r30 | input | 64 | Integer predicate source |
| crf | input | 256 | 64 condition registers, 4 bits each, entry k at [4k+3:4k] |
| mask_valid | output | 1 | Masks are valid |
| mask_ready | input | 1 | Consumer takes the masks |
| dst_mask | output | 64 | Destination element enables |
| src_mask | output | 64 | Source element enables |

## Verification
The assertions assume that the inputs sampled in an accept cycle belong to that request. They also assume that `mask_ready` is driven to a known value on every clock after reset. The stimulus keeps inputs steady across each rising edge by changing them just after the falling edge. It holds `req_valid` high through stalls, so the back-pressure path sees requests that wait. Lengths above 64 and `r3` values above 63 are applied on purpose, to reach the clipping and out-of-range corners.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic {
    PK_INT = 1'b0,
    PK_CR  = 1'b1
  } pred_kind_e;

  typedef enum logic [1:0] {
    CRB_LT = 2'd0,
    CRB_GT = 2'd1,
    CRB_EQ = 2'd2,
    CRB_SO = 2'd3
  } cr_field_e;

  typedef enum logic [1:0] {
    ISRC_SPECIAL = 2'd0,
    ISRC_R3      = 2'd1,
    ISRC_R10     = 2'd2,
    ISRC_R30     = 2'd3
  } int_src_e;
endpackage

// File: rtl/pred_int_sel.sv
module pred_int_sel #(
  parameter int NELEM = 64,
  parameter int XLEN  = 64
) (
  input  logic [2:0]       sel,
  input  logic [XLEN-1:0]  r3,
  input  logic [XLEN-1:0]  r10,
  input  logic [XLEN-1:0]  r30,
  output logic [NELEM-1:0] mask
);
  import pred_pkg::*;

  logic [NELEM-1:0] hot;
  logic [NELEM-1:0] inv;

  assign inv = {NELEM{sel[0]}};

  // one-hot from r3 value; values at or above NELEM match no element (R3)
  for (genvar i = 0; i < NELEM; i++) begin : g_hot
    assign hot[i] = (r3 == XLEN'(i));
  end

  always_comb begin
    unique case (int_src_e'(sel[2:1]))
      ISRC_SPECIAL: mask = sel[0] ? hot : '1;
      ISRC_R3:      mask = r3[NELEM-1:0]  ^ inv;
      ISRC_R10:     mask = r10[NELEM-1:0] ^ inv;
      default:      mask = r30[NELEM-1:0] ^ inv;
    endcase
  end

  // R3: the index code never enables more than one element
  always_comb begin
    if (sel == 3'b001) begin
      p_onehot_r3: assert ($onehot0(mask));
    end
  end
endmodule

// File: rtl/pred_cr_sel.sv
module pred_cr_sel #(
  parameter int NELEM   = 64,
  parameter int NCR     = 64,
  parameter int CRW     = 4,
  parameter int CR_BASE = 32
) (
  input  logic [2:0]         sel,
  input  logic [NCR*CRW-1:0] crf,
  output logic [NELEM-1:0]   mask
);
  import pred_pkg::*;

  // bit position inside an entry: LT is the top bit, SO the lowest
  logic [1:0] pos;
  assign pos = 2'(CRW - 1) - sel[2:1];

  for (genvar i = 0; i < NELEM; i++) begin : g_elem
    if (CR_BASE + i < NCR) begin : g_live
      logic [CRW-1:0] ent;
      assign ent     = crf[(CR_BASE+i)*CRW +: CRW];
      assign mask[i] = ent[pos] ^ sel[0];
    end else begin : g_dead
      assign mask[i] = 1'b0;  // R6: entry beyond the file
    end
  end
endmodule

// File: rtl/pred_len_clip.sv
module pred_len_clip #(
  parameter int NELEM = 64,
  localparam int VLW  = $clog2(NELEM + 1)
) (
  input  logic [VLW-1:0]   vl,
  output logic [NELEM-1:0] lim
);
  for (genvar i = 0; i < NELEM; i++) begin : g_lim
    assign lim[i] = (vl > VLW'(i));
  end
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen #(
  parameter int NELEM   = 64,
  parameter int XLEN    = 64,
  parameter int NCR     = 64,
  parameter int CRW     = 4,
  parameter int CR_BASE = 32,
  localparam int VLW    = $clog2(NELEM + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               kind,
  input  logic [2:0]         dst_sel,
  input  logic [2:0]         src_sel,
  input  logic [VLW-1:0]     vlen,
  input  logic [XLEN-1:0]    r3,
  input  logic [XLEN-1:0]    r10,
  input  logic [XLEN-1:0]    r30,
  input  logic [NCR*CRW-1:0] crf,
  output logic               mask_valid,
  input  logic               mask_ready,
  output logic [NELEM-1:0]   dst_mask,
  output logic [NELEM-1:0]   src_mask
);
  import pred_pkg::*;

  localparam int NSIDE = 2;  // 0 = destination, 1 = source

  logic             fire;
  logic [NELEM-1:0] lim;
  logic [NELEM-1:0] side_mask [NSIDE];

  assign req_ready = !mask_valid || mask_ready;
  assign fire      = req_valid && req_ready;

  pred_len_clip #(.NELEM(NELEM)) u_clip (.vl(vlen), .lim(lim));

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic [2:0]       sel;
    logic [NELEM-1:0] m_int;
    logic [NELEM-1:0] m_cr;
    assign sel = (s == 0) ? dst_sel : src_sel;

    pred_int_sel #(.NELEM(NELEM), .XLEN(XLEN)) u_int (
      .sel(sel), .r3(r3), .r10(r10), .r30(r30), .mask(m_int)
    );
    pred_cr_sel #(.NELEM(NELEM), .NCR(NCR), .CRW(CRW), .CR_BASE(CR_BASE)) u_cr (
      .sel(sel), .crf(crf), .mask(m_cr)
    );

    assign side_mask[s] = ((pred_kind_e'(kind) == PK_CR) ? m_cr : m_int) & lim;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_valid <= 1'b0;
      dst_mask   <= '0;
      src_mask   <= '0;
    end else if (fire) begin
      mask_valid <= 1'b1;
      dst_mask   <= side_mask[0];
      src_mask   <= side_mask[1];
    end else if (mask_ready) begin
      mask_valid <= 1'b0;
    end
  end

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!mask_valid && dst_mask == '0 && src_mask == '0));

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> mask_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mask_valid && !mask_ready) |=> (mask_valid && $stable(dst_mask) && $stable(src_mask)));

  p_len_clip_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && vlen < VLW'(NELEM)) |=>
      ((dst_mask >> $past(vlen)) == '0 && (src_mask >> $past(vlen)) == '0));

  p_cr_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && kind) |=>
      ((dst_mask >> (NCR - CR_BASE)) == '0 && (src_mask >> (NCR - CR_BASE)) == '0));

  p_always_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && !kind && dst_sel == 3'b000 && vlen >= VLW'(NELEM)) |=> (&dst_mask));
endmodule

// File: tb/pred_mask_gen_bench.sv
module pred_mask_gen_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         kind = 1'b0;
  logic [2:0]   dst_sel = '0;
  logic [2:0]   src_sel = '0;
  logic [6:0]   vlen = 7'd64;
  logic [63:0]  r3 = '0, r10 = '0, r30 = '0;
  logic [255:0] crf = '0;
  logic         mask_valid;
  logic         mask_ready = 1'b1;
  logic [63:0]  dst_mask, src_mask;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    live = 1'b0;
  string cur_req = "R11";

  logic        m_valid;
  logic [63:0] m_dst, m_src;

  always #5 clk = ~clk;

  pred_mask_gen u_pred_mask_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .kind(kind), .dst_sel(dst_sel), .src_sel(src_sel), .vlen(vlen),
    .r3(r3), .r10(r10), .r30(r30), .crf(crf),
    .mask_valid(mask_valid), .mask_ready(mask_ready),
    .dst_mask(dst_mask), .src_mask(src_mask)
  );

  function automatic logic [63:0] ref_mask(input logic k, input logic [2:0] sel,
                                           input int vl);
    logic [63:0] m = '0;
    logic [63:0] src;
    for (int i = 0; i < 64; i++) begin
      logic en = 1'b0;
      if (!k) begin
        if (sel == 3'b000) en = 1'b1;
        else if (sel == 3'b001) en = (r3 == 64'(i));
        else begin
          src = (sel[2:1] == 2'd1) ? r3 : (sel[2:1] == 2'd2) ? r10 : r30;
          en = src[i] ^ sel[0];
        end
      end else if (32 + i < 64) begin
        en = crf[4 * (32 + i) + 3 - int'(sel[2:1])] ^ sel[0];
      end
      if (i < vl) m[i] = en;
    end
    return m;
  endfunction

  // behavioural cycle model
  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_dst   <= '0;
      m_src   <= '0;
    end else if (req_valid && (!m_valid || mask_ready)) begin
      m_valid <= 1'b1;
      m_dst   <= ref_mask(kind, dst_sel, int'(vlen));
      m_src   <= ref_mask(kind, src_sel, int'(vlen));
    end else if (mask_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check("mask_valid", 64'(mask_valid), 64'(m_valid));
      check("req_ready", 64'(req_ready), 64'(!m_valid || mask_ready));
      check("dst_mask", dst_mask, m_dst);
      check("src_mask", src_mask, m_src);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic issue(input logic k, input logic [2:0] d, input logic [2:0] s,
                       input logic [6:0] vl);
    kind = k; dst_sel = d; src_sel = s; vlen = vl;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    step();
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    live = 1'b1;
    step();
    cur_req = "R11";
    check("reset_valid", 64'(mask_valid), 64'd0);

    r3  = 64'h0123_4567_89AB_CDEF;
    r10 = 64'hF0F0_0F0F_AA55_33CC;
    r30 = 64'h8000_0000_0000_0001;
    for (int k = 0; k < 64; k++) crf[4*k +: 4] = 4'(k * 7 + 3);

    cur_req = "R2"; issue(0, 3'b000, 3'b000, 7'd64);
    issue(0, 3'b000, 3'b000, 7'd5);
    cur_req = "R8"; issue(0, 3'b000, 3'b010, 7'd0);
    issue(0, 3'b000, 3'b011, 7'd100);
    cur_req = "R4";
    for (int c = 2; c < 8; c++) issue(0, 3'(c), 3'(9 - c), 7'd64);
    issue(0, 3'b101, 3'b110, 7'd37);
    cur_req = "R3";
    r3 = 64'd5;  issue(0, 3'b001, 3'b010, 7'd64);
    r3 = 64'd63; issue(0, 3'b001, 3'b001, 7'd64);
    r3 = 64'd70; issue(0, 3'b001, 3'b000, 7'd64);
    r3 = 64'd10; issue(0, 3'b001, 3'b001, 7'd10);
    cur_req = "R5";
    for (int c = 0; c < 8; c++) issue(1, 3'(c), 3'(7 - c), 7'd64);
    cur_req = "R6"; crf = '1; issue(1, 3'b000, 3'b110, 7'd64);
    cur_req = "R7"; issue(1, 3'b000, 3'b001, 7'd20);
    cur_req = "R1"; crf = '0; r3 = '1; issue(1, 3'b010, 3'b011, 7'd64);
    issue(0, 3'b010, 3'b011, 7'd64);

    cur_req = "R10";
    r10 = 64'h1234_5678_9ABC_DEF0;
    mask_ready = 1'b0;
    kind = 0; dst_sel = 3'b100; src_sel = 3'b101; vlen = 7'd64;
    req_valid = 1'b1;
    step();
    dst_sel = 3'b000;
    for (int n = 0; n < 4; n++) step();
    cur_req = "R9";
    mask_ready = 1'b1;
    step();
    req_valid = 1'b0;
    step(); step();
    for (int n = 0; n < 6; n++) begin
      mask_ready = n[0];
      req_valid  = 1'b1;
      dst_sel    = 3'(n);
      step();
    end
    req_valid = 1'b0;
    mask_ready = 1'b1;
    step(); step();

    cur_req = "R11";
    req_valid = 1'b1;
    step();
    rst = 1'b1;
    req_valid = 1'b0;
    step();
    rst = 1'b0;
    check("reset_after_use", 64'(mask_valid), 64'd0);
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule